// File: doc/BRIEF.md
# Pipelined 3x3 Box Mean Kernel

The block takes one 3x3 neighbourhood of 8-bit pixels per clock, packed into a 72-bit word with a valid flag. It returns the truncated integer mean of the nine pixels as one 8-bit pixel, with its own valid flag, exactly two clock edges later. There are no stalls: a new window may be offered on every cycle, and each one yields its own result.

The first stage gives every pixel a weight of one and registers the weighted taps. The second stage adds the nine taps into a 12-bit sum, divides by nine and registers the result. The divide is a multiply by a reciprocal constant followed by a right shift. The constant is taken from the shift width, and for every reachable sum the result equals exact floor division. When a window arrives with its valid flag low, that stage keeps its contents, so the output pixel holds the last mean it produced.

Top module: `box_mean3x3`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and pixel_o is 0. Reset is asynchronous and clears both stages.
- R2: When valid_o is 1, pixel_o equals floor(S / 9), where S is the sum of the nine pixels of the window accepted two rising edges earlier.
- R3: valid_o equals valid_i as sampled two rising edges earlier. Latency is exactly two cycles.
- R4: Windows offered on consecutive cycles with valid_i high each produce their own result, also on consecutive cycles, with no gaps.
- R5: The full range of sums from 0 to 2295 is handled without overflow. All-255 gives 255, and a sum of 2294 gives 254.
- R6: All nine pixels carry equal weight, so permuting the pixels of a window leaves the result unchanged.
- R7: Pixel p (p = 0..8) occupies bits [8p+7:8p] of win_i.
- R8: A window presented with valid_i low has no effect. When valid_o is 0, pixel_o keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Window on win_i is valid |
| win_i | input | 72 | Nine 8-bit pixels, pixel p at bits [8p+7:8p] |
| valid_o | output | 1 | pixel_o carries a new mean |
| pixel_o | output | 8 | Truncated mean of the window |

## Verification
Two functions can land in the same cycle. In one cycle the first stage may capture a new window while the second stage divides and registers the window before it. In another, a valid-low window may enter the first stage while the second stage emits the last valid mean. Back-to-back windows with alternating extremes, and sum sweeps broken up by garbage windows with valid low, bring both situations about. At every cycle the bench compares valid_o and pixel_o with an arithmetic model of floor(sum/9). That model holds the last mean across each gap.

// File: rtl/box_mean_pkg.sv
package box_mean_pkg;
  localparam int unsigned TAPS      = 9;   // 3x3 neighbourhood
  localparam int unsigned DIV_SHIFT = 16;  // reciprocal precision
  localparam int unsigned COEF      = 1;   // uniform box weight
endpackage

// File: rtl/box_mean_weight_stage.sv
module box_mean_weight_stage #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = box_mean_pkg::TAPS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [TAPS*PIX_W-1:0] win_i,
  output logic                  valid_o,
  output logic [TAPS*PIX_W-1:0] taps_o
);
  localparam logic [PIX_W-1:0] COEF = PIX_W'(box_mean_pkg::COEF);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [PIX_W-1:0] tap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      tap_q <= '0;
      else if (valid_i) tap_q <= PIX_W'(win_i[t*PIX_W +: PIX_W] * COEF);
    end
    assign taps_o[t*PIX_W +: PIX_W] = tap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end
endmodule

// File: rtl/box_mean_sum_div_stage.sv
module box_mean_sum_div_stage #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = box_mean_pkg::TAPS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [TAPS*PIX_W-1:0] taps_i,
  output logic                  valid_o,
  output logic [PIX_W-1:0]      pixel_o
);
  localparam int unsigned SHIFT  = box_mean_pkg::DIV_SHIFT;
  localparam int unsigned SUM_W  = $clog2(TAPS * ((1 << PIX_W) - 1) + 1);
  localparam int unsigned PROD_W = SUM_W + SHIFT;
  // ceil(2^SHIFT / TAPS): exact floor division over the whole sum range
  localparam logic [PROD_W-1:0] RECIP = PROD_W'(((1 << SHIFT) + TAPS - 1) / TAPS);

  logic [SUM_W-1:0]  sum_d;
  logic [PROD_W-1:0] prod_d;
  logic [PROD_W-1:0] quot_d;

  always_comb begin
    sum_d = '0;
    for (int t = 0; t < TAPS; t++) sum_d = sum_d + SUM_W'(taps_i[t*PIX_W +: PIX_W]);
  end

  assign prod_d = PROD_W'(sum_d) * RECIP;
  assign quot_d = prod_d >> SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pixel_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) pixel_o <= PIX_W'(quot_d);
    end
  end
endmodule

// File: rtl/box_mean3x3.sv
module box_mean3x3 #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = box_mean_pkg::TAPS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [TAPS*PIX_W-1:0] win_i,
  output logic                  valid_o,
  output logic [PIX_W-1:0]      pixel_o
);
  logic                  s1_valid;
  logic [TAPS*PIX_W-1:0] s1_taps;

  box_mean_weight_stage #(.PIX_W(PIX_W), .TAPS(TAPS)) u_weight (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .win_i   (win_i),
    .valid_o (s1_valid),
    .taps_o  (s1_taps)
  );

  box_mean_sum_div_stage #(.PIX_W(PIX_W), .TAPS(TAPS)) u_sum_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .taps_i  (s1_taps),
    .valid_o (valid_o),
    .pixel_o (pixel_o)
  );
endmodule

// File: rtl/box_mean3x3_chk.sv
module box_mean3x3_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned TAPS  = box_mean_pkg::TAPS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic [TAPS*PIX_W-1:0] win_i,
  input logic                  valid_o,
  input logic [PIX_W-1:0]      pixel_o
);
  localparam int unsigned SUM_W = $clog2(TAPS * ((1 << PIX_W) - 1) + 1);

  logic [1:0]       age_q;
  logic [SUM_W-1:0] ref_sum;
  logic [PIX_W-1:0] ref_mean;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always_comb begin
    ref_sum = '0;
    for (int t = 0; t < TAPS; t++) ref_sum = ref_sum + SUM_W'(win_i[t*PIX_W +: PIX_W]);
  end
  assign ref_mean = PIX_W'(ref_sum / SUM_W'(TAPS));

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && pixel_o == '0));

  a_r2_exact_mean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && valid_o) |-> pixel_o == $past(ref_mean, 2));

  a_r3_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> valid_o == $past(valid_i, 2));

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(pixel_o));
endmodule

bind box_mean3x3 box_mean3x3_chk #(.PIX_W(PIX_W), .TAPS(TAPS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .win_i   (win_i),
  .valid_o (valid_o),
  .pixel_o (pixel_o)
);

// File: tb/box_mean3x3_tb_top.sv
module box_mean3x3_tb_top;
  localparam int PIX_W = 8;
  localparam int TAPS  = 9;
  localparam int WIN_W = PIX_W * TAPS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b1;
  logic             valid_in = 1'b0;
  logic [WIN_W-1:0] win_in = '0;
  logic             valid_out;
  logic [PIX_W-1:0] pixel_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // bench-side pipeline model, filled from the requirements
  bit   m_sv = 0, m_ov = 0;
  int   m_sp = 0, m_op = 0;
  string m_stag = "R1", m_otag = "R1";

  always #10 clk = ~clk;
  always @(posedge clk) cycles++;

  box_mean3x3 #(.PIX_W(PIX_W), .TAPS(TAPS)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .valid_i (valid_in),
    .win_i   (win_in),
    .valid_o (valid_out),
    .pixel_o (pixel_out)
  );

  function automatic int mean_of(logic [WIN_W-1:0] w);
    int s = 0;
    for (int p = 0; p < TAPS; p++) s += int'(w[p*PIX_W +: PIX_W]);
    return s / TAPS;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [WIN_W-1:0] w, string tag);
    @(negedge clk);
    check(m_ov ? "R3" : "R3 idle", int'(valid_out), int'(m_ov));
    check(m_ov ? m_otag : "R8", int'(pixel_out), m_op);
    valid_in = v;
    win_in   = w;
    m_ov = m_sv;
    if (m_sv) begin m_op = m_sp; m_otag = m_stag; end
    m_sv = v;
    if (v) begin m_sp = mean_of(w); m_stag = tag; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    valid_in = 1'b0;
    win_in = '0;
    #1;
    check("R1 valid", int'(valid_out), 0);
    check("R1 pixel", int'(pixel_out), 0);
    @(negedge clk);
    check("R1 valid held", int'(valid_out), 0);
    check("R1 pixel held", int'(pixel_out), 0);
    m_sv = 0; m_ov = 0; m_sp = 0; m_op = 0;
    rst_n = 1'b1;
  endtask

  function automatic logic [WIN_W-1:0] win_for_sum(int s);
    logic [WIN_W-1:0] w = '0;
    int rem = s;
    for (int p = 0; p < TAPS; p++) begin
      int v = (rem > 255) ? 255 : rem;
      w[p*PIX_W +: PIX_W] = PIX_W'(v);
      rem -= v;
    end
    return w;
  endfunction

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    logic [WIN_W-1:0] w;
    #1 rst_n = 1'b0;
    #1;
    check("R1 valid at start", int'(valid_out), 0);
    check("R1 pixel at start", int'(pixel_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R7: pixel p = 9*(p+1), rest zero -> mean p+1
    for (int p = 0; p < TAPS; p++) begin
      w = '0;
      w[p*PIX_W +: PIX_W] = PIX_W'(9 * (p + 1));
      step(1'b1, w, "R7");
    end

    // R5: extremes
    step(1'b1, {WIN_W{1'b1}}, "R5 all-255");
    step(1'b1, '0, "R5 all-zero");
    step(1'b1, win_for_sum(2294), "R5 sum2294");
    step(1'b1, win_for_sum(2295), "R5 sum2295");

    // R2 + R8: full sum sweep with valid-low garbage gaps
    for (int s = 0; s <= 2295; s++) begin
      step(1'b1, win_for_sum(s), "R2");
      if (s % 7 == 3) step(1'b0, {WIN_W{1'b1}} ^ win_for_sum(s), "R8");
    end

    // R4: alternating extremes back to back
    for (int i = 0; i < 40; i++)
      step(1'b1, (i % 2 == 0) ? {WIN_W{1'b1}} : '0, "R4");

    // R6: random windows and their rotations
    for (int i = 0; i < 200; i++) begin
      for (int p = 0; p < TAPS; p++) w[p*PIX_W +: PIX_W] = PIX_W'($urandom_range(0, 255));
      step(1'b1, w, "R6 base");
      step(1'b1, {w[PIX_W-1:0], w[WIN_W-1:PIX_W]}, "R6 rotated");
      step(1'b1, {w[WIN_W-PIX_W-1:0], w[WIN_W-1 -: PIX_W]}, "R6 rotated back");
    end

    // R8: long idle with garbage, output must hold
    for (int i = 0; i < 6; i++) step(1'b0, {WIN_W{1'b1}}, "R8");

    // R1: reset in mid-stream
    step(1'b1, {WIN_W{1'b1}}, "R1 pre");
    step(1'b1, {WIN_W{1'b1}}, "R1 pre");
    do_reset();
    for (int i = 0; i < 3; i++) step(1'b0, '0, "R1 post");
    for (int i = 0; i < 3; i++) step(1'b1, win_for_sum(100 + i), "R2 after reset");
    for (int i = 0; i < 3; i++) step(1'b0, '0, "drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule